// File: doc/BRIEF.md
# Three-Wire Handshake Byte Transfer Engine

This block is the device end of a byte-serial link to a host processor. The host controls two active-low lines held in a parallel port register: a "transfer active" line and an "acknowledge" line. The device answers on one active-low "request" line. Bytes are not clocked by a serial clock. Each time the host changes the pair of control lines during an active transfer, one byte moves. The byte goes either from the shift register into a packet buffer or from a response buffer into the shift register. The direction is set by a shift-direction input.

Each byte move, each end of transfer, each idle acknowledge toggle and each newly loaded response asks for a shift-register interrupt. That interrupt is deferred by a fixed delay in microseconds, which is turned into clock cycles from a clock-frequency parameter. A new request restarts a pending delay. The delay is skipped when the port direction register is all outputs, or when the delay parameter is zero. When the host ends a transfer that carried bytes, the block pulses a packet-received strobe with the byte count. The collected bytes stay readable through a read port.

Top module: `hs_byte_link`

## Requirements
- R1: After reset `treq_n` is 1, `irq`, `pkt_valid` and `sr_out` are 0, and both buffers count as empty, so a transfer with no bytes ends without a packet strobe and leaves `treq_n` at 1.
- R2: With the active line (`portb_in` bit 5) low and `shift_out_dir` = 1, every cycle in which bit 5 or the acknowledge line (`portb_in` bit 4) differs from its previous-cycle value appends `sr_in` to the packet buffer. When bit 5 next rises, `pkt_valid` pulses for one cycle with `pkt_len` equal to the byte count, and byte i is readable at `pkt_rd_addr` = i.
- R3: During an active transfer, a cycle in which neither bit 5 nor bit 4 changes moves no byte.
- R4: Once the packet buffer holds DEPTH bytes, further host edges store nothing and request no interrupt. The packet then reports exactly DEPTH bytes.
- R5: With bit 5 low and `shift_out_dir` = 0, each qualifying edge loads the next unread response byte into `sr_out` and requests an interrupt. The edge that loads the last byte drives `treq_n` to 1.
- R6: A device-direction edge with no unread response bytes leaves `sr_out` unchanged.
- R7: While bit 5 is high in both the current and the previous cycle, each change of bit 4 copies bit 4 onto `treq_n`.
- R8: The cycle in which bit 5 rises always requests an interrupt. If unread response bytes remain, it drives `treq_n` to 0.
- R9: A request seen at a clock edge raises `irq` for one cycle, DELAY_US*CLK_KHZ/1000 edges later. A new request while one is pending restarts the count, and only one pulse results.
- R10: When `portb_dir` is 8'hFF, a request raises `irq` in the cycle right after the edge that sees it.
- R11: A `rsp_commit` pulse sets the response length to `rsp_len`, rewinds the read position to byte 0 and requests an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| portb_in | input | PORT_W | Port value; bit 5 is the active-low transfer line, bit 4 is the active-low acknowledge line |
| portb_dir | input | PORT_W | Port direction register; all ones bypasses the interrupt delay |
| shift_out_dir | input | 1 | 1: host sends bytes, 0: device sends bytes |
| sr_in | input | DATA_W | Shift register value written by the host |
| sr_out | output | DATA_W | Shift register value loaded by the device |
| treq_n | output | 1 | Active-low request line to the host |
| irq | output | 1 | Shift-register interrupt pulse |
| rsp_wr_en | input | 1 | Write strobe for the response buffer |
| rsp_wr_addr | input | AW | Response buffer write address |
| rsp_wr_data | input | DATA_W | Response buffer write data |
| rsp_commit | input | 1 | Starts a new response of `rsp_len` bytes |
| rsp_len | input | LW | Response length, at most DEPTH |
| pkt_valid | output | 1 | One-cycle strobe: a host packet has completed |
| pkt_len | output | LW | Byte count of the completed packet |
| pkt_rd_addr | input | AW | Packet buffer read address |
| pkt_rd_data | output | DATA_W | Packet buffer byte at `pkt_rd_addr` |

## Verification
The properties assume that the handshake lines change at most once per clock. They also assume that `rsp_commit` never falls in the same cycle as a handshake edge, that `rsp_len` never exceeds DEPTH, and that `shift_out_dir` and `portb_dir` stay steady within a transfer. The stimulus drives every input on the falling clock edge, changes one control line per step, and commits responses only while the link is idle. It also leaves enough idle cycles between scenarios for pending delayed interrupts to drain, so that no pulse from one scenario lands in the next.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
   // bit positions inside the port register that the host firmware decodes
   localparam int unsigned HSL_TIP_BIT  = 5;
   localparam int unsigned HSL_TACK_BIT = 4;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_END     = 2'd1,
      PH_HOST_TX = 2'd2,
      PH_DEV_TX  = 2'd3
   } hsl_phase_e;
endpackage

// File: rtl/hsl_byte_ram.sv
module hsl_byte_ram #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/hsl_irq_delay.sv
module hsl_irq_delay #(
   parameter int unsigned DELAY_CYC = 30,
   localparam int unsigned CW       = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_now,
   input  logic req_late,
   output logic irq
);
   generate
      if (DELAY_CYC == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= req_now | req_late;
         end
      end else begin : g_timed
         logic [CW-1:0] cnt;
         logic          pend;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt  <= '0;
               pend <= 1'b0;
               irq  <= 1'b0;
            end else begin
               irq <= 1'b0;
               if (req_now) begin
                  irq  <= 1'b1;
                  pend <= 1'b0;
               end else if (req_late) begin
                  cnt  <= CW'(DELAY_CYC);
                  pend <= 1'b1;
               end else if (pend) begin
                  if (cnt == CW'(1)) begin
                     irq  <= 1'b1;
                     pend <= 1'b0;
                  end
                  cnt <= cnt - CW'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/hs_byte_link.sv
module hs_byte_link
   import hsl_pkg::*;
#(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PORT_W   = 8,
   parameter int unsigned CLK_KHZ  = 100000,
   parameter int unsigned DELAY_US = 300,
   localparam int unsigned AW        = $clog2(DEPTH),
   localparam int unsigned LW        = $clog2(DEPTH + 1),
   localparam int unsigned DELAY_CYC = (DELAY_US * CLK_KHZ) / 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] portb_in,
   input  logic [PORT_W-1:0] portb_dir,
   input  logic              shift_out_dir,
   input  logic [DATA_W-1:0] sr_in,
   output logic [DATA_W-1:0] sr_out,
   output logic              treq_n,
   output logic              irq,
   input  logic              rsp_wr_en,
   input  logic [AW-1:0]     rsp_wr_addr,
   input  logic [DATA_W-1:0] rsp_wr_data,
   input  logic              rsp_commit,
   input  logic [LW-1:0]     rsp_len,
   output logic              pkt_valid,
   output logic [LW-1:0]     pkt_len,
   input  logic [AW-1:0]     pkt_rd_addr,
   output logic [DATA_W-1:0] pkt_rd_data
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (PORT_W <= HSL_TIP_BIT || PORT_W <= HSL_TACK_BIT) begin : g_bad_port
      $error("PORT_W too narrow for the handshake bit positions");
   end
   if (CLK_KHZ == 0) begin : g_bad_clk
      $error("CLK_KHZ must be non-zero");
   end

   logic              last_tip, last_tack;
   logic [LW-1:0]     out_idx, in_idx, in_size;
   logic [DATA_W-1:0] in_rdata;
   hsl_phase_e        phase;

   wire cur_tip  = portb_in[HSL_TIP_BIT];
   wire cur_tack = portb_in[HSL_TACK_BIT];
   wire pair_chg = (cur_tip != last_tip) || (cur_tack != last_tack);

   always_comb begin
      if (!cur_tip) phase = shift_out_dir ? PH_HOST_TX : PH_DEV_TX;
      else          phase = last_tip ? PH_IDLE : PH_END;
   end

   wire host_cap = (phase == PH_HOST_TX) && pair_chg && (out_idx < LW'(DEPTH));
   wire dev_load = (phase == PH_DEV_TX) && pair_chg && (in_idx < in_size);
   wire sync_tgl = (phase == PH_IDLE) && (cur_tack != last_tack);
   wire xfer_end = (phase == PH_END);
   wire sched    = host_cap | dev_load | sync_tgl | xfer_end | rsp_commit;
   wire bypass   = (portb_dir == {PORT_W{1'b1}});

   wire [LW-1:0] in_next = in_idx + LW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_tip  <= cur_tip;
         last_tack <= cur_tack;
         out_idx   <= '0;
         in_idx    <= '0;
         in_size   <= '0;
         treq_n    <= 1'b1;
         sr_out    <= '0;
         pkt_valid <= 1'b0;
         pkt_len   <= '0;
      end else begin
         last_tip  <= cur_tip;
         last_tack <= cur_tack;
         pkt_valid <= 1'b0;
         if (host_cap) out_idx <= out_idx + LW'(1);
         if (dev_load) begin
            sr_out <= in_rdata;
            in_idx <= in_next;
            if (in_next >= in_size) treq_n <= 1'b1;
         end
         if (sync_tgl) treq_n <= cur_tack;
         if (xfer_end) begin
            if (in_idx < in_size) treq_n <= 1'b0;
            if (out_idx != '0) begin
               pkt_valid <= 1'b1;
               pkt_len   <= out_idx;
               out_idx   <= '0;
            end
         end
         if (rsp_commit) begin
            in_idx  <= '0;
            in_size <= rsp_len;
         end
      end
   end

   hsl_byte_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_pkt_buf (
      .clk   (clk),
      .we    (host_cap),
      .waddr (out_idx[AW-1:0]),
      .wdata (sr_in),
      .raddr (pkt_rd_addr),
      .rdata (pkt_rd_data)
   );

   hsl_byte_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rsp_buf (
      .clk   (clk),
      .we    (rsp_wr_en),
      .waddr (rsp_wr_addr),
      .wdata (rsp_wr_data),
      .raddr (in_idx[AW-1:0]),
      .rdata (in_rdata)
   );

   hsl_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_now  (sched & bypass),
      .req_late (sched & ~bypass),
      .irq      (irq)
   );
endmodule

// File: rtl/hsl_link_chk.sv
module hsl_link_chk
   import hsl_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned PORT_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LW     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] portb_in,
   input logic [PORT_W-1:0] portb_dir,
   input logic              shift_out_dir,
   input logic              rsp_commit,
   input logic [DATA_W-1:0] sr_out,
   input logic              treq_n,
   input logic              irq,
   input logic              pkt_valid,
   input logic [LW-1:0]     pkt_len
);
   // R2
   pkt_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len != '0 && pkt_len <= LW'(DEPTH)));

   // R8
   pkt_on_tip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> ($past(portb_in[HSL_TIP_BIT]) && !$past(portb_in[HSL_TIP_BIT], 2)));

   // R5
   sr_load_dev_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sr_out) |-> $past(!portb_in[HSL_TIP_BIT] && !shift_out_dir));

   // R7
   idle_sync_treq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (portb_in[HSL_TIP_BIT] && $past(portb_in[HSL_TIP_BIT]) &&
       portb_in[HSL_TACK_BIT] != $past(portb_in[HSL_TACK_BIT]))
      |=> (treq_n == $past(portb_in[HSL_TACK_BIT])));

   // R10
   bypass_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (portb_dir == {PORT_W{1'b1}} && rsp_commit) |=> irq);
endmodule

bind hs_byte_link hsl_link_chk #(
   .DEPTH(DEPTH), .PORT_W(PORT_W), .DATA_W(DATA_W), .LW(LW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .portb_in(portb_in), .portb_dir(portb_dir),
   .shift_out_dir(shift_out_dir), .rsp_commit(rsp_commit), .sr_out(sr_out),
   .treq_n(treq_n), .irq(irq), .pkt_valid(pkt_valid), .pkt_len(pkt_len)
);

// File: tb/tb_hs_byte_link.sv
module tb_hs_byte_link;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int CLK_KHZ    = 100;
   localparam int DELAY_US   = 300;
   localparam int DLY        = DELAY_US * CLK_KHZ / 1000;
   localparam int AW         = $clog2(DEPTH);
   localparam int LW         = $clog2(DEPTH + 1);

   // host-send vectors: {tip, tack, expect_capture, sr_in[7:0]}
   localparam logic [10:0] HOST_TBL [6] = '{
      {1'b0, 1'b1, 1'b1, 8'h11},
      {1'b0, 1'b0, 1'b1, 8'h22},
      {1'b0, 1'b0, 1'b0, 8'h33},
      {1'b0, 1'b1, 1'b1, 8'h44},
      {1'b0, 1'b0, 1'b1, 8'h55},
      {1'b1, 1'b0, 1'b0, 8'h66}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      portb_in = 8'h30;
   logic [7:0]      portb_dir = 8'h00;
   logic            shift_out_dir = 1'b0;
   logic [7:0]      sr_in = 8'h00;
   logic [7:0]      sr_out;
   logic            treq_n;
   logic            irq;
   logic            rsp_wr_en = 1'b0;
   logic [AW-1:0]   rsp_wr_addr = '0;
   logic [7:0]      rsp_wr_data = 8'h00;
   logic            rsp_commit = 1'b0;
   logic [LW-1:0]   rsp_len = '0;
   logic            pkt_valid;
   logic [LW-1:0]   pkt_len;
   logic [AW-1:0]   pkt_rd_addr = '0;
   logic [7:0]      pkt_rd_data;

   int checks = 0;
   int errors = 0;
   logic cur_tip = 1'b1;
   logic cur_tack = 1'b1;
   logic [7:0] exp_bytes [DEPTH];
   int exp_n;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hs_byte_link #(.DEPTH(DEPTH), .CLK_KHZ(CLK_KHZ), .DELAY_US(DELAY_US)) dut (
      .clk(clk), .rst_n(rst_n), .portb_in(portb_in), .portb_dir(portb_dir),
      .shift_out_dir(shift_out_dir), .sr_in(sr_in), .sr_out(sr_out),
      .treq_n(treq_n), .irq(irq), .rsp_wr_en(rsp_wr_en),
      .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
      .rsp_commit(rsp_commit), .rsp_len(rsp_len), .pkt_valid(pkt_valid),
      .pkt_len(pkt_len), .pkt_rd_addr(pkt_rd_addr), .pkt_rd_data(pkt_rd_data)
   );

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive lines (bit 5 = tip, bit 4 = tack), return at the sample point
   task automatic set_lines(input logic tip, input logic tack);
      cur_tip  = tip;
      cur_tack = tack;
      portb_in = {2'b00, tip, tack, 4'b0000};
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load_rsp(input logic [7:0] base, input int n);
      for (int i = 0; i < n; i++) begin
         rsp_wr_en   = 1'b1;
         rsp_wr_addr = AW'(i);
         rsp_wr_data = base + 8'(i);
         @(negedge clk);
      end
      rsp_wr_en = 1'b0;
   endtask

   task automatic commit(input int n);
      rsp_len    = LW'(n);
      rsp_commit = 1'b1;
      @(negedge clk);
      rsp_commit = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      // R1 reset state
      check("R1", "treq_n", treq_n, 1);
      check("R1", "irq", irq, 0);
      check("R1", "pkt_valid", pkt_valid, 0);
      check("R1", "sr_out", sr_out, 0);
      rst_n = 1'b1;
      idle(2);
      // R1 empty transfer in device direction: no packet, no request
      set_lines(1'b0, 1'b1);
      check("R1", "sr_out empty", sr_out, 0);
      set_lines(1'b1, 1'b1);
      check("R1", "no pkt", pkt_valid, 0);
      check("R1", "treq_n idle", treq_n, 1);
      idle(DLY + 5);

      // R2/R3 host send table
      shift_out_dir = 1'b1;
      exp_n = 0;
      for (int e = 0; e < 6; e++) begin
         logic was_tip;
         was_tip = cur_tip;
         sr_in = HOST_TBL[e][7:0];
         if (HOST_TBL[e][8]) begin
            exp_bytes[exp_n] = HOST_TBL[e][7:0];
            exp_n++;
         end
         set_lines(HOST_TBL[e][10], HOST_TBL[e][9]);
         check((HOST_TBL[e][10] && !was_tip) ? "R2" : "R3", "pkt_valid",
               pkt_valid, (HOST_TBL[e][10] && !was_tip) ? 1 : 0);
      end
      check("R2", "pkt_len", pkt_len, exp_n);
      for (int i = 0; i < exp_n; i++) begin
         pkt_rd_addr = AW'(i);
         #1;
         check("R2", "pkt byte", pkt_rd_data, exp_bytes[i]);
      end
      idle(DLY + 5);

      // R9 delayed interrupt timing
      shift_out_dir = 1'b0;
      commit(0);
      for (int j = 0; j <= DLY + 1; j++) begin
         if (j == DLY - 1 || j == DLY || j == DLY + 1)
            check("R9", "irq timing", irq, (j == DLY) ? 1 : 0);
         @(negedge clk);
      end
      // R9 restart on a second request
      commit(0);
      idle(10);
      commit(0);
      begin
         int pulses = 0;
         int at = -1;
         for (int j = 0; j <= DLY + 2; j++) begin
            if (irq) begin pulses++; at = j; end
            @(negedge clk);
         end
         check("R9", "restart pulse count", pulses, 1);
         check("R9", "restart pulse time", at, DLY);
      end
      idle(5);

      // R4 packet buffer overflow, with bypass (R10) for direct irq
      portb_dir = 8'hFF;
      shift_out_dir = 1'b1;
      for (int k = 1; k <= DEPTH + 1; k++) begin
         sr_in = 8'(k);
         if (k == 1) set_lines(1'b0, 1'b1);
         else        set_lines(1'b0, ~cur_tack);
         if (k == DEPTH || k == DEPTH + 1)
            check("R4", "irq per edge", irq, (k <= DEPTH) ? 1 : 0);
      end
      set_lines(1'b1, cur_tack);
      check("R4", "pkt_valid", pkt_valid, 1);
      check("R4", "pkt_len", pkt_len, DEPTH);
      check("R10", "irq end", irq, 1);
      pkt_rd_addr = AW'(DEPTH - 1);
      #1;
      check("R4", "last byte", pkt_rd_data, DEPTH);
      idle(3);

      // R5/R6 device send with delayed irq
      portb_dir = 8'h00;
      shift_out_dir = 1'b0;
      set_lines(1'b1, 1'b1);
      load_rsp(8'hA0, 3);
      commit(3);
      set_lines(1'b0, 1'b1);
      check("R5", "byte0", sr_out, 8'hA0);
      set_lines(1'b0, 1'b0);
      check("R5", "byte1", sr_out, 8'hA1);
      set_lines(1'b0, 1'b1);
      check("R5", "byte2", sr_out, 8'hA2);
      check("R5", "treq_n end", treq_n, 1);
      set_lines(1'b0, 1'b0);
      check("R6", "no reload", sr_out, 8'hA2);
      set_lines(1'b1, 1'b0);
      check("R8", "treq_n none pending", treq_n, 1);
      idle(DLY + 5);

      // R8/R10/R11 pending response at end of transfer, bypassed irq
      portb_dir = 8'hFF;
      set_lines(1'b1, 1'b1);
      load_rsp(8'hB0, 2);
      commit(2);
      check("R11", "irq on commit", irq, 1);
      set_lines(1'b0, 1'b1);
      check("R11", "first byte", sr_out, 8'hB0);
      set_lines(1'b1, 1'b1);
      check("R8", "treq_n pending", treq_n, 0);
      check("R8", "irq at end", irq, 1);
      // R7 idle sync
      set_lines(1'b1, 1'b0);
      check("R7", "treq follows 0", treq_n, 0);
      set_lines(1'b1, 1'b1);
      check("R7", "treq follows 1", treq_n, 1);
      check("R7", "irq on toggle", irq, 1);
      set_lines(1'b1, 1'b0);
      check("R7", "treq follows 0 again", treq_n, 0);
      // R11 rewind to byte 0
      commit(2);
      set_lines(1'b0, 1'b0);
      check("R11", "rewind byte", sr_out, 8'hB0);
      set_lines(1'b1, 1'b0);
      idle(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule